// File: doc/BRIEF.md
# Iterative TEA Block Encryptor

This block encrypts one 64-bit block with the Tiny Encryption Algorithm under a 128-bit key. Software or a neighbouring block writes the key and the plaintext through two load strobes, then raises `ready` for one cycle. The engine runs the 32 Feistel cycles one after another. Each cycle is made of two half-round mixing steps, so 64 steps run in total.

All arithmetic goes through one shared 32-bit datapath. That datapath provides a modular adder, an XOR and two fixed shifters. The shifters move left by four and right by five, and the right shift is logical.

The sequencing is done by a fixed microprogram. It is held as three parallel constant tables, one for the opcode, one for the first operand and one for the second operand, all addressed by a single instruction counter. The program moves words from an input store into a register file. That file holds ten general-purpose registers plus an accumulator, and the two data halves live in two fixed registers of it. A loop counter repeats the round body.

When the program halts, `complete` goes high and `result` carries the ciphertext. Both hold until the next start is accepted.

Top module: `tea_engine`

## Requirements
- R1: After reset, `complete` is 0 and `result` is all zeros.
- R2: A cycle with `ready`=1 while the engine is idle starts a run. In the following cycle `complete` is 0, and it stays 0 until the run finishes.
- R3: At completion, `result` equals the TEA encryption of the stored block under the stored key. The encryption runs 32 cycles. In each cycle the running sum first gains the constant 0x9E3779B9, starting from zero. Then v0 += ((v1<<4)+k0) ^ (v1+sum) ^ ((v1>>5)+k1). Then v1 += ((v0<<4)+k2) ^ (v0+sum) ^ ((v0>>5)+k3). All of this is modulo 2^32.
- R4: Word layout. k0 is `key_in[127:96]`, k1 is `key_in[95:64]`, k2 is `key_in[63:32]` and k3 is `key_in[31:0]`. v0 is `data_in[63:32]` and v1 is `data_in[31:0]`. `result` is {v0, v1} in the same layout.
- R5: Once `complete` is 1, it and `result` stay unchanged until a new start is accepted. This holds even if load strobes arrive in the meantime.
- R6: `ready` is ignored while a run is in progress. Such a pulse neither restarts nor lengthens the run, and it does not change the result.
- R7: `key_load` and `data_load` are ignored while a run is in progress. A later run started without reloading encrypts the words stored before that run.
- R8: While the engine is idle, `key_load` stores `key_in` and `data_load` stores `data_in`, each independently of the other. The next run uses the stored words.
- R9: The number of cycles from the accepting edge of `ready` to the rise of `complete` is the same for every run, whatever the key and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Store `key_in` into the key words (idle only) |
| key_in | input | 128 | Key, k0 in the top word |
| data_load | input | 1 | Store `data_in` into the block words (idle only) |
| data_in | input | 64 | Plaintext, v0 in the top word |
| ready | input | 1 | Start request, taken when idle |
| complete | output | 1 | High from the end of a run until the next start |
| result | output | 64 | Ciphertext {v0, v1} |

## Verification
The round arithmetic feeds back on itself. A wrong opcode, operand, shift amount or loop count therefore changes almost every ciphertext bit, and this shows at `result` at the rise of `complete`, roughly 800 cycles after the start.

A fault in the sequencer shows earlier and in a different way. It appears as a changed run length, as a `complete` that drops or never rises, or as a restart when `ready` is pulsed mid-run.

A fault in the input store stays hidden until a later run. For that reason the bench repeats runs without reloading and compares them against a reference model.

// File: rtl/tea_pkg.sv
package tea_pkg;

    localparam int OPND_W = 6;

    typedef enum logic [3:0] {
        OP_LDC   = 4'd0,
        OP_LDM   = 4'd1,
        OP_MOV   = 4'd2,
        OP_ADD   = 4'd3,
        OP_XOR   = 4'd4,
        OP_SHL   = 4'd5,
        OP_SHR   = 4'd6,
        OP_LPSET = 4'd7,
        OP_LOOP  = 4'd8,
        OP_HALT  = 4'd9
    } op_e;

    // register file slots
    localparam logic [OPND_W-1:0] RG_K0  = 6'd0;
    localparam logic [OPND_W-1:0] RG_K1  = 6'd1;
    localparam logic [OPND_W-1:0] RG_K2  = 6'd2;
    localparam logic [OPND_W-1:0] RG_K3  = 6'd3;
    localparam logic [OPND_W-1:0] RG_V0  = 6'd4;
    localparam logic [OPND_W-1:0] RG_V1  = 6'd5;
    localparam logic [OPND_W-1:0] RG_SUM = 6'd6;
    localparam logic [OPND_W-1:0] RG_DLT = 6'd7;
    localparam logic [OPND_W-1:0] RG_TMP = 6'd8;
    localparam logic [OPND_W-1:0] RG_ACC = 6'd10;

    localparam int REG_N = 11;

    // program label
    localparam logic [OPND_W-1:0] PC_BODY = 6'd9;

endpackage

// File: rtl/tea_ucode_rom.sv
module tea_ucode_rom
    import tea_pkg::*;
(
    input  logic [OPND_W-1:0] pc,
    output op_e               op,
    output logic [OPND_W-1:0] opa,
    output logic [OPND_W-1:0] opb
);

    // opcode table
    always_comb begin
        case (pc)
            6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5: op = OP_LDM;
            6'd6, 6'd7:                         op = OP_LDC;
            6'd8:                               op = OP_LPSET;
            6'd10, 6'd13, 6'd16, 6'd21,
            6'd24, 6'd27, 6'd32:                op = OP_MOV;
            6'd11, 6'd22:                       op = OP_SHL;
            6'd17, 6'd28:                       op = OP_SHR;
            6'd15, 6'd19, 6'd26, 6'd30:         op = OP_XOR;
            6'd9, 6'd12, 6'd14, 6'd18, 6'd20,
            6'd23, 6'd25, 6'd29, 6'd31:         op = OP_ADD;
            6'd33:                              op = OP_LOOP;
            default:                            op = OP_HALT;
        endcase
    end

    // first operand table: source register, store index, constant select or jump target
    always_comb begin
        case (pc)
            6'd0:  opa = 6'd0;
            6'd1:  opa = 6'd1;
            6'd2:  opa = 6'd2;
            6'd3:  opa = 6'd3;
            6'd4:  opa = 6'd4;
            6'd5:  opa = 6'd5;
            6'd6:  opa = 6'd0;
            6'd7:  opa = 6'd1;
            6'd9:  opa = RG_SUM;
            6'd11: opa = RG_V1;
            6'd14: opa = RG_V1;
            6'd17: opa = RG_V1;
            6'd22: opa = RG_V0;
            6'd25: opa = RG_V0;
            6'd28: opa = RG_V0;
            6'd33: opa = PC_BODY;
            6'd10, 6'd12, 6'd13, 6'd15, 6'd16, 6'd18, 6'd19, 6'd20, 6'd21,
            6'd23, 6'd24, 6'd26, 6'd27, 6'd29, 6'd30, 6'd31, 6'd32:
                   opa = RG_ACC;
            default: opa = '0;
        endcase
    end

    // second operand table: destination register or second source
    always_comb begin
        case (pc)
            6'd0:  opb = RG_K0;
            6'd1:  opb = RG_K1;
            6'd2:  opb = RG_K2;
            6'd3:  opb = RG_K3;
            6'd4:  opb = RG_V0;
            6'd5:  opb = RG_V1;
            6'd6:  opb = RG_SUM;
            6'd7:  opb = RG_DLT;
            6'd9:  opb = RG_DLT;
            6'd10: opb = RG_SUM;
            6'd12: opb = RG_K0;
            6'd13: opb = RG_TMP;
            6'd14: opb = RG_SUM;
            6'd15: opb = RG_TMP;
            6'd16: opb = RG_TMP;
            6'd18: opb = RG_K1;
            6'd19: opb = RG_TMP;
            6'd20: opb = RG_V0;
            6'd21: opb = RG_V0;
            6'd23: opb = RG_K2;
            6'd24: opb = RG_TMP;
            6'd25: opb = RG_SUM;
            6'd26: opb = RG_TMP;
            6'd27: opb = RG_TMP;
            6'd29: opb = RG_K3;
            6'd30: opb = RG_TMP;
            6'd31: opb = RG_V1;
            6'd32: opb = RG_V1;
            default: opb = '0;
        endcase
    end

endmodule

// File: rtl/tea_alu.sv
module tea_alu
    import tea_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int SHL_AMT = 4,
    parameter int SHR_AMT = 5
) (
    input  op_e               op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_XOR:  y = a ^ b;
            OP_SHL:  y = a << SHL_AMT;
            OP_SHR:  y = a >> SHR_AMT;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/tea_regfile.sv
module tea_regfile #(
    parameter int WORD_W = 32,
    parameter int N      = 11,
    parameter int AW     = 6,
    parameter int OBS0   = 4,
    parameter int OBS1   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [WORD_W-1:0] rdata_a,
    output logic [WORD_W-1:0] rdata_b,
    output logic [WORD_W-1:0] obs0,
    output logic [WORD_W-1:0] obs1
);

    logic [N-1:0][WORD_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d  = regs_q;
        rdata_a = '0;
        rdata_b = '0;
        for (int i = 0; i < N; i++) begin
            if (we && waddr == AW'(i)) regs_d[i] = wdata;
            if (raddr_a == AW'(i))     rdata_a   = regs_q[i];
            if (raddr_b == AW'(i))     rdata_b   = regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign obs0 = regs_q[OBS0];
    assign obs1 = regs_q[OBS1];

endmodule

// File: rtl/tea_engine.sv
module tea_engine
    import tea_pkg::*;
#(
    parameter int          WORD_W = 32,
    parameter int          ROUNDS = 32,
    parameter logic [31:0] DELTA  = 32'h9E3779B9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                key_load,
    input  logic [4*WORD_W-1:0] key_in,
    input  logic                data_load,
    input  logic [2*WORD_W-1:0] data_in,
    input  logic                ready,
    output logic                complete,
    output logic [2*WORD_W-1:0] result
);

    localparam int KEY_N = 4;
    localparam int MEM_N = KEY_N + 2;
    localparam int CNT_W = $clog2(ROUNDS + 1);

    typedef struct packed {
        logic                         busy;
        logic                         complete;
        logic [OPND_W-1:0]            pc;
        logic [CNT_W-1:0]             loop_cnt;
        logic [MEM_N-1:0][WORD_W-1:0] mem;
    } state_t;

    state_t st_d, st_q;

    op_e               op;
    logic [OPND_W-1:0] opa, opb;
    logic [WORD_W-1:0] rd_a, rd_b, alu_y, v0_w, v1_w;
    logic              rf_we;
    logic [OPND_W-1:0] rf_waddr;
    logic [WORD_W-1:0] rf_wdata;
    logic [WORD_W-1:0] mem_word;

    tea_ucode_rom u_rom (
        .pc  (st_q.pc),
        .op  (op),
        .opa (opa),
        .opb (opb)
    );

    tea_regfile #(
        .WORD_W (WORD_W),
        .N      (REG_N),
        .AW     (OPND_W),
        .OBS0   (int'(RG_V0)),
        .OBS1   (int'(RG_V1))
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (opa),
        .raddr_b (opb),
        .rdata_a (rd_a),
        .rdata_b (rd_b),
        .obs0    (v0_w),
        .obs1    (v1_w)
    );

    tea_alu #(.WORD_W(WORD_W), .SHL_AMT(4), .SHR_AMT(5)) u_alu (
        .op (op),
        .a  (rd_a),
        .b  (rd_b),
        .y  (alu_y)
    );

    always_comb begin
        mem_word = '0;
        for (int i = 0; i < MEM_N; i++)
            if (opa == OPND_W'(i)) mem_word = st_q.mem[i];
    end

    always_comb begin
        st_d     = st_q;
        rf_we    = 1'b0;
        rf_waddr = '0;
        rf_wdata = '0;
        if (!st_q.busy) begin
            if (key_load)
                for (int i = 0; i < KEY_N; i++)
                    st_d.mem[i] = key_in[WORD_W*(KEY_N-1-i) +: WORD_W];
            if (data_load) begin
                st_d.mem[KEY_N]   = data_in[WORD_W +: WORD_W];
                st_d.mem[KEY_N+1] = data_in[0 +: WORD_W];
            end
            if (ready) begin
                st_d.busy     = 1'b1;
                st_d.complete = 1'b0;
                st_d.pc       = '0;
            end
        end else begin
            st_d.pc = st_q.pc + 1'b1;
            case (op)
                OP_LDC: begin
                    rf_we    = 1'b1;
                    rf_waddr = opb;
                    rf_wdata = (opa == OPND_W'(1)) ? DELTA[WORD_W-1:0] : '0;
                end
                OP_LDM: begin
                    rf_we    = 1'b1;
                    rf_waddr = opb;
                    rf_wdata = mem_word;
                end
                OP_MOV: begin
                    rf_we    = 1'b1;
                    rf_waddr = opb;
                    rf_wdata = rd_a;
                end
                OP_ADD, OP_XOR, OP_SHL, OP_SHR: begin
                    rf_we    = 1'b1;
                    rf_waddr = RG_ACC;
                    rf_wdata = alu_y;
                end
                OP_LPSET: st_d.loop_cnt = CNT_W'(ROUNDS);
                OP_LOOP: begin
                    st_d.loop_cnt = st_q.loop_cnt - 1'b1;
                    if (st_q.loop_cnt != CNT_W'(1)) st_d.pc = opa;
                end
                default: begin
                    st_d.busy     = 1'b0;
                    st_d.complete = 1'b1;
                    st_d.pc       = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign complete = st_q.complete;
    assign result   = {v0_w, v1_w};

endmodule

// File: rtl/tea_engine_chk.sv
module tea_engine_chk #(
    parameter int ROUNDS = 32,
    parameter int CNT_W  = 6,
    parameter int PC_W   = 6,
    parameter int RES_W  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ready,
    input logic             busy,
    input logic             complete,
    input logic [PC_W-1:0]  pc,
    input logic [CNT_W-1:0] loop_cnt,
    input logic [RES_W-1:0] result
);

    // accepted start clears completion and begins the run
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy) |=> (busy && !complete));

    // a finished run never overlaps an active one
    assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !complete);

    // completion only rises at the end of a run
    assert_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(complete) |-> $past(busy));

    // result and completion hold while no start arrives
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (complete && !ready) |=> (complete && $stable(result)));

    // ready during a run does not send the sequencer back to the start
    assert_norestart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ready) |=> (pc != '0 || complete));

    // loop counter never exceeds the round count
    assert_loopcnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_cnt <= CNT_W'(ROUNDS));

endmodule

bind tea_engine tea_engine_chk #(
    .ROUNDS (ROUNDS),
    .CNT_W  (CNT_W),
    .PC_W   (tea_pkg::OPND_W),
    .RES_W  (2*WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .busy     (st_q.busy),
    .complete (complete),
    .pc       (st_q.pc),
    .loop_cnt (st_q.loop_cnt),
    .result   (result)
);

// File: tb/tb_tea_engine.sv
module tb_tea_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [127:0] key_in = '0;
    logic         data_load = 1'b0;
    logic [63:0]  data_in = '0;
    logic         ready = 1'b0;
    logic         complete;
    logic [63:0]  result;

    int checks = 0;
    int errors = 0;
    int ref_lat = -1;

    always #10 clk = ~clk;

    tea_engine dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_load  (key_load),
        .key_in    (key_in),
        .data_load (data_load),
        .data_in   (data_in),
        .ready     (ready),
        .complete  (complete),
        .result    (result)
    );

    localparam int NV = 6;
    localparam logic [191:0] VEC [NV] = '{
        {128'h0, 64'h0},
        {128'h00000000_00000000_00000000_00000000, 64'h00000001_00000000},
        {128'h01234567_89ABCDEF_FEDCBA98_76543210, 64'h01234567_89ABCDEF},
        {128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF},
        {128'h80000000_00000001_7FFFFFFF_DEADBEEF, 64'hCAFEF00D_12345678},
        {128'h0F0F0F0F_F0F0F0F0_33333333_CCCCCCCC, 64'h55555555_AAAAAAAA}
    };

    function automatic logic [63:0] tea_ref(input logic [127:0] k, input logic [63:0] d);
        logic [31:0] y, z, s;
        y = d[63:32];
        z = d[31:0];
        s = '0;
        for (int i = 0; i < 32; i++) begin
            s = s + 32'h9E3779B9;
            y = y + (((z << 4) + k[127:96]) ^ (z + s) ^ ((z >> 5) + k[95:64]));
            z = z + (((y << 4) + k[63:32]) ^ (y + s) ^ ((y >> 5) + k[31:0]));
        end
        return {y, z};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input bit dok, input logic [127:0] k, input bit ddo, input logic [63:0] d);
        @(negedge clk);
        key_load  = dok;
        key_in    = k;
        data_load = ddo;
        data_in   = d;
        @(negedge clk);
        key_load  = 1'b0;
        data_load = 1'b0;
    endtask

    // mode 0 plain, 1 ready pulses mid-run, 2 load strobes mid-run
    task automatic run(input int mode, output logic [63:0] res, output int lat);
        @(negedge clk);
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
        lat = 1;
        chk(complete == 1'b0, "R2 complete low after start", {63'd0, complete}, 64'd0);
        while (!complete && lat < 5000) begin
            if (mode == 1 && (lat == 50 || lat == 400)) ready = 1'b1;
            if (mode == 2 && lat == 300) begin
                key_load  = 1'b1; key_in  = {4{32'h13579BDF}};
                data_load = 1'b1; data_in = {2{32'h2468ACE0}};
            end
            @(negedge clk);
            ready = 1'b0; key_load = 1'b0; data_load = 1'b0;
            lat++;
        end
        if (!complete) begin
            errors++;
            checks++;
            $display("FAIL R3 run never completed actual=%0d expected=<5000", lat);
        end
        res = result;
        if (ref_lat < 0) ref_lat = lat;
        chk(lat == ref_lat, "R9 latency", 64'(lat), 64'(ref_lat));
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] r, r2, e;
        int lat;
        logic [127:0] k;
        logic [63:0]  d;

        repeat (3) @(negedge clk);
        chk(complete == 1'b0, "R1 complete at reset", {63'd0, complete}, 64'd0);
        chk(result == 64'd0, "R1 result at reset", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(complete == 1'b0 && result == 64'd0, "R1 after release", result, 64'd0);

        // R3/R4 vectors against the model
        for (int v = 0; v < NV; v++) begin
            k = VEC[v][191:64];
            d = VEC[v][63:0];
            load(1'b1, k, 1'b1, d);
            run(0, r, lat);
            e = tea_ref(k, d);
            chk(r == e, "R3 R4 ciphertext", r, e);
        end

        // R5: hold while idle, loads do not disturb result
        r = result;
        load(1'b1, 128'hAAAA, 1'b1, 64'h5555);
        repeat (20) @(negedge clk);
        chk(complete == 1'b1, "R5 complete held", {63'd0, complete}, 64'd1);
        chk(result == r, "R5 result held", result, r);

        // R6: ready pulses during the run
        k = VEC[2][191:64];
        d = VEC[2][63:0];
        load(1'b1, k, 1'b1, d);
        run(1, r, lat);
        e = tea_ref(k, d);
        chk(r == e, "R6 ready ignored while busy", r, e);

        // R7: loads mid-run ignored; rerun without reload repeats
        run(2, r, lat);
        chk(r == e, "R7 run with mid-run loads", r, e);
        run(0, r2, lat);
        chk(r2 == e, "R7 rerun uses stored words", r2, e);

        // R8: independent loads
        load(1'b0, 128'h0, 1'b1, 64'h00000000_FFFFFFFF);
        run(0, r, lat);
        e = tea_ref(k, 64'h00000000_FFFFFFFF);
        chk(r == e, "R8 data only load", r, e);
        load(1'b1, 128'h1, 1'b0, 64'h0);
        run(0, r, lat);
        e = tea_ref(128'h1, 64'h00000000_FFFFFFFF);
        chk(r == e, "R8 key only load", r, e);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule